// File: doc/BRIEF.md
# SMBus Master Transaction Sequencer

This block runs one SMBus master transaction at a time. Software first loads a transmit queue. Each entry holds a byte and an end-of-write mark in bit 8. The first entry is the target address in bits [7:1] with the read/write-not flag in bit 0. The entries that follow are an optional command code, an optional count and the data bytes. Software then writes a protocol code together with a start bit. From then on the block sequences the whole transaction. It does this by issuing byte-level operations to a separate bus engine, which handles the SCL/SDA bit timing.

Each engine operation is a level request with a stable opcode. The engine acknowledges it with a one-cycle done pulse. With that pulse the engine returns three things: the target's ACK for a write, the byte for a read, and an error code. Received bytes go into a receive queue that software reads. At the end of the transaction the block drops `busy_o` and reports a completion code.

Top module: `smb_seq`

## Requirements
- R1: Protocol codes are: 0 quick, 1 send byte, 2 receive byte, 3 write byte, 4 read byte, 5 write word, 6 read word, 7 block write, 8 block read, 9 process call, 10 block-write/block-read call.
  - A command write with start set raises `busy_o` in the next cycle, but only when the block is idle and `cfg_en_i` is high. While disabled the command is ignored.
  - `busy_o` clears by itself when the transaction ends, and `status_o` is updated at that moment.
- R2: Engine opcodes are: 0 START, 1 repeated START, 2 WRITE, 3 READ, 4 STOP.
  - A transaction begins with START.
  - After START, one WRITE is issued per transmit entry, in queue order, carrying bits [7:0].
  - The write phase ends after the entry whose bit 8 is set, or when the queue runs empty.
- R3: Protocols 4, 6, 8, 9 and 10 continue after the write phase with a repeated START. They then WRITE the stored address with bit 0 set to 1.
- R4: Receive byte and read byte take 1 byte. Read word and process call take 2 bytes.
  - Every READ is flagged ACK except the last READ, which is flagged NACK.
  - STOP follows the last READ.
- R5: For protocols 8 and 10 the first READ returns a count. The count is pushed to the receive queue.
  - min(count, 32) data bytes follow the count.
  - A count of 0 goes straight to STOP.
- R6: Protocols 0, 1, 3, 5 and 7 issue STOP right after the write phase. A transaction with no error reports status 0.
- R7: A target NACK on the first WRITE ends the transaction with status 2. A NACK on any later WRITE ends it with status 3. Either way STOP is issued.
- R8: A nonzero engine error code on any operation (1 lost arbitration, 4 timeout, 5 transmit clock-low, 6 receive clock-low) becomes the status. STOP is issued after every error except lost arbitration (1).
- R9: After an error, the remaining transmit entries of that transaction are discarded, up to and including the entry marked end-of-write. Entries behind it stay in the queue.
- R10: Received bytes, including a block count, appear in arrival order on `rx_data_o`. `rx_pop_i` consumes them.
- R11: `tx_flush_i` empties the transmit queue and `rx_flush_i` empties the receive queue. `cfg_srst_i` empties both, returns the block to idle and clears the status.
- R12: `eng_fast_o` follows the speed-select input `cfg_fast_i` (0 for 100 kHz, 1 for 400 kHz).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_en_i | input | 1 | Block enable |
| cfg_srst_i | input | 1 | Soft reset |
| cfg_fast_i | input | 1 | Speed select, 1 = 400 kHz |
| cmd_we_i | input | 1 | Command register write strobe |
| cmd_start_i | input | 1 | Start bit of the command write |
| cmd_proto_i | input | 4 | Protocol code |
| busy_o | output | 1 | Transaction in progress |
| status_o | output | 3 | Completion code of the last transaction |
| tx_push_i | input | 1 | Push a transmit entry |
| tx_data_i | input | 9 | Entry: bit 8 end-of-write, bits [7:0] byte |
| tx_full_o | output | 1 | Transmit queue full |
| tx_empty_o | output | 1 | Transmit queue empty |
| tx_flush_i | input | 1 | Empty the transmit queue |
| rx_pop_i | input | 1 | Pop the receive queue |
| rx_data_o | output | 8 | Head of the receive queue |
| rx_empty_o | output | 1 | Receive queue empty |
| rx_flush_i | input | 1 | Empty the receive queue |
| eng_req_o | output | 1 | Engine operation request |
| eng_op_o | output | 3 | Engine opcode |
| eng_wdata_o | output | 8 | Byte for a WRITE |
| eng_nack_o | output | 1 | READ to be answered with NACK |
| eng_done_i | input | 1 | Operation complete, one-cycle pulse |
| eng_ack_i | input | 1 | Target ACKed the WRITE |
| eng_rdata_i | input | 8 | Byte returned by a READ |
| eng_err_i | input | 3 | Engine error code, 0 for none |
| eng_fast_o | output | 1 | Speed select toward the engine |

## Verification
The bench aims at these corner cases:
- Block reads with a count of 0 or above 32. A design that does not clamp the count would over-read the target.
- A missing end-of-write mark. The write phase should end when the queue runs empty.
- Errors injected part-way through a write. A faulty drain would either leave stale entries behind or eat the next transaction's address.
- Lost arbitration. The bench checks that no STOP follows it.
- A NACK on the first byte versus a later byte. Confusing the two shows up as status 2 against status 3.

A wrong ACK/NACK choice on the last read, or a missing repeated START, shows up as a mismatch in the engine operation sequence. The bench checks that sequence as each operation completes.

// File: rtl/smb_seq_pkg.sv
package smb_seq_pkg;
  typedef enum logic [2:0] {
    OP_START  = 3'd0,
    OP_RSTART = 3'd1,
    OP_WRITE  = 3'd2,
    OP_READ   = 3'd3,
    OP_STOP   = 3'd4
  } bus_op_e;

  localparam logic [3:0] PR_RECV  = 4'd2;
  localparam logic [3:0] PR_RDB   = 4'd4;
  localparam logic [3:0] PR_RDW   = 4'd6;
  localparam logic [3:0] PR_BLKRD = 4'd8;
  localparam logic [3:0] PR_PCALL = 4'd9;
  localparam logic [3:0] PR_BWBR  = 4'd10;

  localparam logic [2:0] ST_LOSTARB = 3'd1;
  localparam logic [2:0] ST_NACK1   = 3'd2;
  localparam logic [2:0] ST_NACKN   = 3'd3;
endpackage

// File: rtl/smb_seq_fifo.sv
module smb_seq_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 64
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         flush_i,
  input  logic         push_i,
  input  logic [W-1:0] data_i,
  input  logic         pop_i,
  output logic [W-1:0] data_o,
  output logic         empty_o,
  output logic         full_o
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0] mem [DEPTH];
  logic [AW-1:0] rp_q, wp_q;
  logic [AW:0]   cnt_q;
  logic do_push, do_pop;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == (AW+1)'(DEPTH));
  assign do_push = push_i && !full_o && !flush_i;
  assign do_pop  = pop_i && !empty_o && !flush_i;
  assign data_o  = mem[rp_q];

  always_ff @(posedge clk_i) begin
    if (do_push) mem[wp_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rp_q <= '0; wp_q <= '0; cnt_q <= '0;
    end else if (flush_i) begin
      rp_q <= '0; wp_q <= '0; cnt_q <= '0;
    end else begin
      if (do_push) wp_q <= (wp_q == AW'(DEPTH-1)) ? '0 : wp_q + 1'b1;
      if (do_pop)  rp_q <= (rp_q == AW'(DEPTH-1)) ? '0 : rp_q + 1'b1;
      cnt_q <= cnt_q + (AW+1)'(do_push) - (AW+1)'(do_pop);
    end
  end

  // full queue drops a lone push
  assert_no_overflow_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && full_o && !pop_i && !flush_i) |=> $stable(cnt_q));
endmodule

// File: rtl/smb_seq_ctrl.sv
module smb_seq_ctrl
  import smb_seq_pkg::*;
#(
  parameter int BLK_MAX = 32
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       srst_i,
  input  logic       en_i,
  input  logic       start_i,
  input  logic [3:0] proto_i,
  output logic       busy_o,
  output logic [2:0] status_o,
  input  logic [8:0] tx_data_i,
  input  logic       tx_empty_i,
  output logic       tx_pop_o,
  output logic       rx_push_o,
  output logic [7:0] rx_data_o,
  output logic       eng_req_o,
  output bus_op_e    eng_op_o,
  output logic [7:0] eng_wdata_o,
  output logic       eng_nack_o,
  input  logic       eng_done_i,
  input  logic       eng_ack_i,
  input  logic [7:0] eng_rdata_i,
  input  logic [2:0] eng_err_i
);
  localparam int CW = $clog2(BLK_MAX + 1);

  typedef enum logic [2:0] {
    S_IDLE, S_START, S_WR, S_RSTART, S_RADDR, S_RD, S_DRAIN, S_STOP
  } state_e;

  state_e        state_q, aw_state;
  logic [3:0]    proto_q;
  logic [6:0]    addr_q;
  logic          first_q, end_q, bc_q;
  logic [CW-1:0] left_q, left_init;
  logic [2:0]    code_q, status_q;
  logic          is_rd, need_rs, is_blk;
  logic [7:0]    blk_n;

  always_comb begin
    need_rs  = proto_q inside {PR_RDB, PR_RDW, PR_BLKRD, PR_PCALL, PR_BWBR};
    is_rd    = need_rs || (proto_q == PR_RECV);
    is_blk   = proto_q inside {PR_BLKRD, PR_BWBR};
    aw_state = need_rs ? S_RSTART : (is_rd ? S_RD : S_STOP);
    left_init = (proto_q inside {PR_RDW, PR_PCALL}) ? CW'(2) : CW'(1);
    blk_n    = (eng_rdata_i > 8'(BLK_MAX)) ? 8'(BLK_MAX) : eng_rdata_i;
  end

  always_comb begin
    eng_op_o = OP_WRITE;
    unique case (state_q)
      S_START:  eng_op_o = OP_START;
      S_RSTART: eng_op_o = OP_RSTART;
      S_RD:     eng_op_o = OP_READ;
      S_STOP:   eng_op_o = OP_STOP;
      default:  eng_op_o = OP_WRITE;
    endcase
  end

  assign busy_o      = (state_q != S_IDLE);
  assign status_o    = status_q;
  assign eng_req_o   = (state_q inside {S_START, S_RSTART, S_RADDR, S_RD, S_STOP}) ||
                       (state_q == S_WR && !tx_empty_i);
  assign eng_wdata_o = (state_q == S_RADDR) ? {addr_q, 1'b1} : tx_data_i[7:0];
  assign eng_nack_o  = (state_q == S_RD) && !bc_q && (left_q == CW'(1));
  assign tx_pop_o    = (state_q == S_WR && eng_done_i) ||
                       (state_q == S_DRAIN && !tx_empty_i && !end_q);
  assign rx_push_o   = (state_q == S_RD) && eng_done_i && (eng_err_i == 3'd0);
  assign rx_data_o   = eng_rdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE; proto_q <= '0; addr_q <= '0; first_q <= 1'b0;
      end_q <= 1'b0; bc_q <= 1'b0; left_q <= '0; code_q <= '0; status_q <= '0;
    end else if (srst_i) begin
      state_q <= S_IDLE; code_q <= '0; status_q <= '0;
    end else begin
      unique case (state_q)
        S_IDLE: if (start_i && en_i) begin
          proto_q <= proto_i; first_q <= 1'b1; end_q <= 1'b0; code_q <= '0;
          state_q <= S_START;
        end
        S_START: if (eng_done_i) begin
          if (eng_err_i != 3'd0) begin code_q <= eng_err_i; state_q <= S_DRAIN; end
          else state_q <= S_WR;
        end
        S_WR: begin
          if (tx_empty_i) begin
            state_q <= aw_state; left_q <= left_init; bc_q <= is_blk;
          end else if (eng_done_i) begin
            first_q <= 1'b0;
            if (first_q) addr_q <= tx_data_i[7:1];
            if (tx_data_i[8]) end_q <= 1'b1;
            if (eng_err_i != 3'd0) begin
              code_q <= eng_err_i; state_q <= S_DRAIN;
            end else if (!eng_ack_i) begin
              code_q <= first_q ? ST_NACK1 : ST_NACKN; state_q <= S_DRAIN;
            end else if (tx_data_i[8]) begin
              state_q <= aw_state; left_q <= left_init; bc_q <= is_blk;
            end
          end
        end
        S_RSTART: if (eng_done_i) begin
          if (eng_err_i != 3'd0) begin code_q <= eng_err_i; state_q <= S_DRAIN; end
          else state_q <= S_RADDR;
        end
        S_RADDR: if (eng_done_i) begin
          if (eng_err_i != 3'd0) begin code_q <= eng_err_i; state_q <= S_DRAIN; end
          else if (!eng_ack_i) begin code_q <= ST_NACKN; state_q <= S_DRAIN; end
          else state_q <= S_RD;
        end
        S_RD: if (eng_done_i) begin
          if (eng_err_i != 3'd0) begin
            code_q <= eng_err_i; state_q <= S_DRAIN;
          end else if (bc_q) begin
            bc_q <= 1'b0;
            left_q <= CW'(blk_n);
            if (blk_n == 8'd0) state_q <= S_STOP;
          end else begin
            left_q <= left_q - 1'b1;
            if (left_q == CW'(1)) state_q <= S_STOP;
          end
        end
        S_DRAIN: begin
          if (tx_pop_o && tx_data_i[8]) end_q <= 1'b1;
          if (tx_empty_i || end_q) begin
            if (code_q == ST_LOSTARB) begin status_q <= code_q; state_q <= S_IDLE; end
            else state_q <= S_STOP;
          end
        end
        S_STOP: if (eng_done_i) begin
          status_q <= (code_q != 3'd0) ? code_q : eng_err_i;
          state_q  <= S_IDLE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assert_idle_hold_R1: assert property (@(posedge clk_i) disable iff (!rst_ni || srst_i)
    (!busy_o && !(start_i && en_i)) |=> !busy_o);
  assert_req_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni || srst_i)
    (eng_req_o && !eng_done_i && state_q != S_WR) |=> (eng_req_o && $stable(eng_op_o)));
  assert_nack_read_only_R4: assert property (@(posedge clk_i) disable iff (!rst_ni || srst_i)
    (eng_req_o && eng_nack_o) |-> (eng_op_o == OP_READ));
  assert_no_stop_lostarb_R8: assert property (@(posedge clk_i) disable iff (!rst_ni || srst_i)
    (eng_done_i && eng_err_i == ST_LOSTARB) |=> !(eng_req_o && eng_op_o == OP_STOP));
  assert_rx_from_read_R10: assert property (@(posedge clk_i) disable iff (!rst_ni || srst_i)
    rx_push_o |-> (eng_op_o == OP_READ && eng_done_i));
endmodule

// File: rtl/smb_seq.sv
module smb_seq
  import smb_seq_pkg::*;
#(
  parameter int TX_DEPTH = 64,
  parameter int RX_DEPTH = 64,
  parameter int BLK_MAX  = 32
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cfg_en_i,
  input  logic       cfg_srst_i,
  input  logic       cfg_fast_i,
  input  logic       cmd_we_i,
  input  logic       cmd_start_i,
  input  logic [3:0] cmd_proto_i,
  output logic       busy_o,
  output logic [2:0] status_o,
  input  logic       tx_push_i,
  input  logic [8:0] tx_data_i,
  output logic       tx_full_o,
  output logic       tx_empty_o,
  input  logic       tx_flush_i,
  input  logic       rx_pop_i,
  output logic [7:0] rx_data_o,
  output logic       rx_empty_o,
  input  logic       rx_flush_i,
  output logic       eng_req_o,
  output logic [2:0] eng_op_o,
  output logic [7:0] eng_wdata_o,
  output logic       eng_nack_o,
  input  logic       eng_done_i,
  input  logic       eng_ack_i,
  input  logic [7:0] eng_rdata_i,
  input  logic [2:0] eng_err_i,
  output logic       eng_fast_o
);
  logic [8:0] txh;
  logic       tx_pop, rx_push;
  logic [7:0] rx_in;
  bus_op_e    op;

  assign eng_op_o   = op;
  assign eng_fast_o = cfg_fast_i;

  smb_seq_fifo #(.W(9), .DEPTH(TX_DEPTH)) u_txq (
    .clk_i, .rst_ni, .flush_i(tx_flush_i || cfg_srst_i),
    .push_i(tx_push_i), .data_i(tx_data_i), .pop_i(tx_pop),
    .data_o(txh), .empty_o(tx_empty_o), .full_o(tx_full_o)
  );

  smb_seq_fifo #(.W(8), .DEPTH(RX_DEPTH)) u_rxq (
    .clk_i, .rst_ni, .flush_i(rx_flush_i || cfg_srst_i),
    .push_i(rx_push), .data_i(rx_in), .pop_i(rx_pop_i),
    .data_o(rx_data_o), .empty_o(rx_empty_o), .full_o()
  );

  smb_seq_ctrl #(.BLK_MAX(BLK_MAX)) u_ctrl (
    .clk_i, .rst_ni, .srst_i(cfg_srst_i), .en_i(cfg_en_i),
    .start_i(cmd_we_i && cmd_start_i), .proto_i(cmd_proto_i),
    .busy_o, .status_o, .tx_data_i(txh), .tx_empty_i(tx_empty_o),
    .tx_pop_o(tx_pop), .rx_push_o(rx_push), .rx_data_o(rx_in),
    .eng_req_o, .eng_op_o(op), .eng_wdata_o, .eng_nack_o,
    .eng_done_i, .eng_ack_i, .eng_rdata_i, .eng_err_i
  );
endmodule

// File: tb/smb_seq_test.sv
`timescale 1ns/1ps
module smb_seq_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic en = 1'b1, srst = 1'b0, fast = 1'b0;
  logic cmd_we = 1'b0, cmd_start = 1'b0;
  logic [3:0] proto = '0;
  logic busy;
  logic [2:0] status;
  logic tx_push = 1'b0, tx_full, tx_empty, tx_flush = 1'b0;
  logic [8:0] tx_data = '0;
  logic rx_pop = 1'b0, rx_empty, rx_flush = 1'b0;
  logic [7:0] rx_data;
  logic eng_req, eng_nack, eng_fast;
  logic [2:0] eng_op;
  logic [7:0] eng_wdata;
  logic eng_done = 1'b0, eng_ack = 1'b1;
  logic [7:0] eng_rdata = '0;
  logic [2:0] eng_err = '0;

  int n_tests = 0, n_fail = 0;
  int op_k = 0, lat = 0;
  int nack_op = -1, err_op = -1, err_code = 0;
  bit chk_ops = 1'b1;
  logic [8:0] model_q[$];
  int tgt_q[$];
  int exp_key[$];
  int exp_rx[$];
  int exp_status;

  always #2.5 clk = ~clk;

  smb_seq uut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_en_i(en), .cfg_srst_i(srst), .cfg_fast_i(fast),
    .cmd_we_i(cmd_we), .cmd_start_i(cmd_start), .cmd_proto_i(proto),
    .busy_o(busy), .status_o(status),
    .tx_push_i(tx_push), .tx_data_i(tx_data), .tx_full_o(tx_full), .tx_empty_o(tx_empty),
    .tx_flush_i(tx_flush), .rx_pop_i(rx_pop), .rx_data_o(rx_data), .rx_empty_o(rx_empty),
    .rx_flush_i(rx_flush), .eng_req_o(eng_req), .eng_op_o(eng_op), .eng_wdata_o(eng_wdata),
    .eng_nack_o(eng_nack), .eng_done_i(eng_done), .eng_ack_i(eng_ack),
    .eng_rdata_i(eng_rdata), .eng_err_i(eng_err), .eng_fast_o(eng_fast)
  );

  task automatic chk(bit ok, string req, int act, int expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, expv);
    end
  endtask

  function automatic int key(int op, int d, int n);
    if (op == 2) return (op << 9) | ((d & 255) << 1);
    if (op == 3) return (op << 9) | (n & 1);
    return op << 9;
  endfunction

  function automatic int emit(int op, int d, int n, bit wr);
    int k = exp_key.size();
    exp_key.push_back(key(op, d, n));
    if (k == err_op) return err_code;
    if (wr && k == nack_op) return 8;
    return 0;
  endfunction

  // behavioural byte engine: fixed latency, scripted replies, live sequence check
  always @(negedge clk) begin
    if (eng_done) begin
      eng_done = 1'b0; eng_err = '0; eng_ack = 1'b1;
    end else if (eng_req) begin
      if (lat < 2) lat++;
      else begin
        int e;
        lat = 0;
        e = (op_k < exp_key.size()) ? exp_key[op_k] : -1;
        if (chk_ops) chk(key(eng_op, eng_wdata, eng_nack) == e, "R2/R3/R4 engine op sequence",
                         key(eng_op, eng_wdata, eng_nack), e);
        eng_err = (op_k == err_op) ? 3'(err_code) : 3'd0;
        eng_ack = !(op_k == nack_op);
        if (eng_op == 3'd3) eng_rdata = (tgt_q.size() > 0) ? 8'(tgt_q.pop_front()) : 8'hFF;
        eng_done = 1'b1;
        op_k++;
      end
    end else lat = 0;
  end

  task automatic model(int pr);
    int rq[$];
    int st = 0, r, n, b;
    int addr = 0;
    bit first = 1'b1;
    bit rs, rd, blk;
    rq = tgt_q;
    exp_key.delete(); exp_rx.delete();
    rs  = (pr == 4 || pr == 6 || pr == 8 || pr == 9 || pr == 10);
    rd  = rs || pr == 2;
    blk = (pr == 8 || pr == 10);
    r = emit(0, 0, 0, 0);
    if (r != 0) st = r;
    if (st == 0) begin
      for (int i = 0; i < model_q.size(); i++) begin
        r = emit(2, model_q[i][7:0], 0, 1);
        if (first) addr = model_q[i][7:1];
        if (r == 8) st = first ? 2 : 3;
        else if (r != 0) st = r;
        first = 1'b0;
        if (st != 0 || model_q[i][8]) break;
      end
    end
    if (st == 0 && rd) begin
      if (rs) begin
        r = emit(1, 0, 0, 0);
        if (r != 0) st = r;
        else begin
          r = emit(2, (addr << 1) | 1, 0, 1);
          if (r != 0) st = (r == 8) ? 3 : r;
        end
      end
      if (st == 0) begin
        n = (pr == 6 || pr == 9) ? 2 : 1;
        if (blk) begin
          r = emit(3, 0, 0, 0);
          if (r != 0) st = r;
          else begin
            b = rq.pop_front();
            exp_rx.push_back(b);
            n = (b > 32) ? 32 : b;
          end
        end
        if (st == 0) begin
          for (int i = 0; i < n; i++) begin
            r = emit(3, 0, (i == n - 1) ? 1 : 0, 0);
            if (r != 0) begin st = r; break; end
            exp_rx.push_back(rq.pop_front());
          end
        end
      end
    end
    if (st != 1) begin
      r = emit(4, 0, 0, 0);
      if (st == 0 && r != 0) st = r;
    end
    exp_status = st;
  endtask

  task automatic push_entry(logic [8:0] v);
    @(negedge clk); tx_push = 1'b1; tx_data = v;
    @(negedge clk); tx_push = 1'b0;
  endtask

  task automatic issue(int pr);
    @(negedge clk); cmd_we = 1'b1; cmd_start = 1'b1; proto = 4'(pr);
    @(negedge clk); cmd_we = 1'b0; cmd_start = 1'b0;
  endtask

  task automatic run_txn(int pr, bit do_push, bit expect_txe, string tag);
    int t = 0;
    op_k = 0;
    model(pr);
    if (do_push) foreach (model_q[i]) push_entry(model_q[i]);
    issue(pr);
    while (busy && t < 5000) begin @(negedge clk); t++; end
    @(negedge clk);
    chk(!busy, {tag, " busy clears"}, busy, 0);
    chk(status == 3'(exp_status), {tag, " status"}, status, exp_status);
    chk(op_k == exp_key.size(), {tag, " op count"}, op_k, exp_key.size());
    chk(tx_empty == expect_txe, {tag, " R9 tx queue after txn"}, tx_empty, expect_txe);
    foreach (exp_rx[i]) begin
      chk(!rx_empty && rx_data == 8'(exp_rx[i]), {tag, " R10 rx byte"}, rx_data, exp_rx[i]);
      rx_pop = 1'b1; @(negedge clk); rx_pop = 1'b0;
    end
    chk(rx_empty, {tag, " R10 rx drained"}, rx_empty, 1);
    nack_op = -1; err_op = -1; err_code = 0; tgt_q.delete();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "WATCHDOG", 0, 1);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(!busy && status == 0 && tx_empty && rx_empty && !eng_req, "R1 reset state",
        {busy, status, tx_empty, rx_empty, eng_req}, 7'b0000110);

    // R6 quick command ok
    model_q = '{9'h1A0};
    run_txn(0, 1, 1, "R6 quick");
    // R7 quick NACK on address
    model_q = '{9'h1A0}; nack_op = 1;
    run_txn(0, 1, 1, "R7 quick nack");
    // R6 send byte
    model_q = '{9'h0A0, 9'h155};
    run_txn(1, 1, 1, "R6 send byte");
    // R7 write word, NACK on last data byte
    model_q = '{9'h0A0, 9'h010, 9'h011, 9'h112}; nack_op = 4;
    run_txn(5, 1, 1, "R7 write word nack");
    // R3 R4 read byte
    model_q = '{9'h0A0, 9'h107}; tgt_q = '{8'h3C};
    run_txn(4, 1, 1, "R3 R4 read byte");
    // R4 read word
    model_q = '{9'h0A0, 9'h108}; tgt_q = '{8'h11, 8'h22};
    run_txn(6, 1, 1, "R4 read word");
    // R4 receive byte (no repeated start)
    model_q = '{9'h1A1}; tgt_q = '{8'h5A};
    run_txn(2, 1, 1, "R4 receive byte");
    // R3 R4 process call
    model_q = '{9'h0A0, 9'h005, 9'h066, 9'h177}; tgt_q = '{8'h99, 8'h88};
    run_txn(9, 1, 1, "R4 process call");
    // R6 block write
    model_q = '{9'h0A0, 9'h003, 9'h001, 9'h002, 9'h103};
    run_txn(7, 1, 1, "R6 block write");
    // R5 block read count 3
    model_q = '{9'h0A0, 9'h109}; tgt_q = '{3, 8'hA1, 8'hA2, 8'hA3};
    run_txn(8, 1, 1, "R5 block read");
    // R5 block read count above limit
    model_q = '{9'h0A0, 9'h109};
    tgt_q.push_back(40);
    for (int i = 0; i < 40; i++) tgt_q.push_back(i + 16);
    run_txn(8, 1, 1, "R5 block read clamp");
    // R5 block read count zero
    model_q = '{9'h0A0, 9'h109}; tgt_q = '{0};
    run_txn(8, 1, 1, "R5 block read zero");
    // R5 block-write/block-read call
    model_q = '{9'h0A0, 9'h00C, 9'h002, 9'h0AA, 9'h1BB}; tgt_q = '{2, 8'h71, 8'h72};
    run_txn(10, 1, 1, "R5 bw-br call");
    // R8 R9 lost arbitration on START: no STOP, entries drained
    model_q = '{9'h0A0, 9'h010, 9'h011, 9'h112}; err_op = 0; err_code = 1;
    run_txn(5, 1, 1, "R8 lost arbitration");
    // R8 R9 timeout mid-write; entry of the next txn must survive
    model_q = '{9'h0A0, 9'h010, 9'h011, 9'h112};
    foreach (model_q[i]) push_entry(model_q[i]);
    push_entry(9'h1B0);
    err_op = 2; err_code = 4;
    run_txn(5, 0, 0, "R9 timeout drain");
    model_q = '{9'h1B0};
    run_txn(0, 0, 1, "R9 next txn intact");
    // R8 receive clock-low error on READ
    model_q = '{9'h0A0, 9'h107}; tgt_q = '{8'h3C}; err_op = 5; err_code = 6;
    run_txn(4, 1, 1, "R8 read error");
    // R2 missing end mark: write phase ends on empty queue
    model_q = '{9'h0A0, 9'h010};
    run_txn(3, 1, 1, "R2 empty ends write");

    // R1 disabled: start ignored
    begin
      int bad = 0;
      en = 1'b0;
      push_entry(9'h1A0);
      issue(0);
      for (int i = 0; i < 20; i++) begin
        @(negedge clk);
        if (busy || eng_req) bad++;
      end
      chk(bad == 0, "R1 disabled start ignored", bad, 0);
      chk(!tx_empty, "R1 entry untouched while disabled", tx_empty, 0);
      en = 1'b1;
    end
    // R11 tx flush
    @(negedge clk); tx_flush = 1'b1; @(negedge clk); tx_flush = 1'b0;
    chk(tx_empty, "R11 tx flush", tx_empty, 1);

    // R11 rx flush
    model_q = '{9'h1A1}; tgt_q = '{8'h44};
    op_k = 0; model(2);
    push_entry(9'h1A1);
    issue(2);
    for (int t = 0; t < 100 && busy; t++) @(negedge clk);
    chk(!rx_empty && rx_data == 8'h44, "R10 rx byte held", rx_data, 8'h44);
    rx_flush = 1'b1; @(negedge clk); rx_flush = 1'b0;
    chk(rx_empty, "R11 rx flush", rx_empty, 1);
    tgt_q.delete();

    // R12 speed pass-through
    fast = 1'b1; @(negedge clk);
    chk(eng_fast == 1'b1, "R12 fast mode", eng_fast, 1);
    fast = 1'b0; @(negedge clk);
    chk(eng_fast == 1'b0, "R12 standard mode", eng_fast, 0);

    // R11 soft reset mid transaction; status nonzero beforehand
    model_q = '{9'h1A0}; nack_op = 1;
    run_txn(0, 1, 1, "R7 setup nack");
    chk_ops = 1'b0;
    push_entry(9'h0A0); push_entry(9'h108); push_entry(9'h0C0);
    tgt_q = '{1, 2};
    issue(6);
    repeat (6) @(negedge clk);
    srst = 1'b1; @(negedge clk); srst = 1'b0; @(negedge clk);
    chk(!busy, "R11 soft reset idles", busy, 0);
    chk(status == 0, "R11 soft reset clears status", status, 0);
    chk(tx_empty && rx_empty, "R11 soft reset empties queues", {tx_empty, rx_empty}, 2'b11);
    repeat (4) @(negedge clk);
    chk(!eng_req, "R11 no request after soft reset", eng_req, 0);
    tgt_q.delete(); chk_ops = 1'b1;

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule